// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock for an I2C master from a much faster peripheral clock. A power-of-two prescaler divides the peripheral clock into base ticks. The high phase of SCL lasts a programmable number of base ticks, and so does the low phase. All three settings come from one packed timing word written by software. The SCL period is therefore 2^B × ((H+1) + (L+1)) peripheral cycles, where B is the exponent field, H the high field and L the low field.

The byte engine that drives SDA follows the phase output. It also uses two one-cycle strobes. One strobe marks each rising edge of SCL, which is where a new period begins. The other marks each falling edge. The generator runs only while its enable is high. When disabled it releases SCL and returns to a clean starting point. A timing word written while the generator runs is adopted only where the next period begins, so a phase already in progress never changes length.

Top module: `i2c_scl_timer`

## Requirements
- R1: The timing word packs the fields as follows: high-phase count H in bits 19:16, low-phase count L in bits 15:12, base exponent B in bits 3:0. Bits 11:4 have no effect on any output.
- R2: Each high phase of `scl_o` (value 1) lasts exactly (H+1)×2^B clock cycles.
- R3: Each low phase of `scl_o` (value 0) lasts (L+1)×2^B cycles, so a full period is (H+L+2)×2^B cycles.
- R4: `rise_stb` is high for exactly the first cycle in which `scl_o` is 1 after having been 0. `fall_stb` is high for exactly the first cycle in which `scl_o` is 0 after having been 1. While enabled, `scl_o` changes only together with one of these strobes.
- R5: In the cycle after `en` is sampled low, `scl_o` is 1 and both strobes are 0. The next time `en` is set, the generator starts with a full high phase that uses the word present at the last disabled clock edge.
- R6: The generator captures a new timing word only at the edge where SCL rises. A word changed in the middle of a period does not alter that period's remaining high or low phase.
- R7: With all fields zero, the period is 2 cycles: one cycle high and one cycle low.
- R8: The largest fields are timed exactly. With H=L=15, each phase is 16×2^B cycles. With B=15, each tick is 32768 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds SCL released and clears the counters |
| timing_word | input | 20 | Packed timing word: H at [19:16], L at [15:12], B at [3:0] |
| scl_o | output | 1 | SCL phase: 1 for high (released), 0 for low |
| rise_stb | output | 1 | One-cycle strobe at the start of each high phase |
| fall_stb | output | 1 | One-cycle strobe at the start of each low phase |

## Verification
The bench targets the following corner cases.
- Off-by-one phase lengths: a design that counts the stored fields without the +1 would give a zero-length phase at H=0 or L=0, and the all-zero word would then never toggle.
- Prescaler width: if the prescaler wraps at the wrong value for B=15, the 32768-cycle tick comes out short.
- Timing-word changes mid-period: a design that follows the word live would stretch or cut the phase in progress, and the per-cycle comparison catches it in the cycle where that phase ends.
- Disable in the middle of a low phase: a design that keeps a stale prescaler or phase count would start its next high phase short.

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int CNT_W    = 4,
  parameter int EXP_W    = 4,
  parameter int HI_LSB   = 16,
  parameter int LO_LSB   = 12,
  parameter int BASE_LSB = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [HI_LSB+CNT_W-1:0]    timing_word,
  output logic                       scl_o,
  output logic                       rise_stb,
  output logic                       fall_stb
);
  localparam int PRE_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] act_hi, act_lo, ph_cnt, ph_lim;
  logic [EXP_W-1:0] act_base;
  logic [PRE_W-1:0] pre_cnt, pre_lim;
  logic             tick, ph_end;

  assign pre_lim = ~({PRE_W{1'b1}} << act_base);
  assign tick    = (pre_cnt == pre_lim);
  assign ph_lim  = scl_o ? act_hi : act_lo;
  assign ph_end  = tick && (ph_cnt == ph_lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      ph_cnt   <= '0;
      scl_o    <= 1'b1;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
      act_hi   <= '0;
      act_lo   <= '0;
      act_base <= '0;
    end else if (!en) begin
      pre_cnt  <= '0;
      ph_cnt   <= '0;
      scl_o    <= 1'b1;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
      act_hi   <= timing_word[HI_LSB +: CNT_W];
      act_lo   <= timing_word[LO_LSB +: CNT_W];
      act_base <= timing_word[BASE_LSB +: EXP_W];
    end else begin
      rise_stb <= ph_end && !scl_o;
      fall_stb <= ph_end && scl_o;
      pre_cnt  <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) ph_cnt <= ph_end ? '0 : ph_cnt + 1'b1;
      if (ph_end) begin
        scl_o <= !scl_o;
        if (!scl_o) begin
          act_hi   <= timing_word[HI_LSB +: CNT_W];
          act_lo   <= timing_word[LO_LSB +: CNT_W];
          act_base <= timing_word[BASE_LSB +: EXP_W];
        end
      end
    end
  end

  p_rise_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (scl_o && !$past(scl_o)));

  p_fall_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!scl_o && $past(scl_o)));

  p_toggle_strobed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && (scl_o != $past(scl_o))) |-> (rise_stb || fall_stb));

  p_idle_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_o && !rise_stb && !fall_stb));

  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ph_cnt <= ph_lim);

  p_word_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !rise_stb) |-> $stable(act_hi));
endmodule

// File: tb/tb_i2c_scl_timer.sv
module tb_i2c_scl_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [19:0] timing_word = '0;
  logic        scl_o, rise_stb, fall_stb;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  i2c_scl_timer dut (
    .clk(clk), .rst_n(rst_n), .en(en), .timing_word(timing_word),
    .scl_o(scl_o), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  always #5 clk = !clk;

  int m_left, m_b, m_h, m_l;
  bit m_scl = 1'b1, m_rise = 1'b0, m_fall = 1'b0;

  function automatic logic [19:0] word(int b, int h, int l, int junk);
    return 20'((h << 16) | (l << 12) | ((junk & 8'hff) << 4) | b);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || !en) begin
      m_scl = 1'b1; m_rise = 1'b0; m_fall = 1'b0;
      m_h = int'(timing_word[19:16]); m_l = int'(timing_word[15:12]); m_b = int'(timing_word[3:0]);
      m_left = (m_h + 1) << m_b;
    end else begin
      m_rise = 1'b0; m_fall = 1'b0;
      m_left--;
      if (m_left == 0) begin
        if (m_scl) begin
          m_scl = 1'b0; m_fall = 1'b1; m_left = (m_l + 1) << m_b;
        end else begin
          m_scl = 1'b1; m_rise = 1'b1;
          m_h = int'(timing_word[19:16]); m_l = int'(timing_word[15:12]); m_b = int'(timing_word[3:0]);
          m_left = (m_h + 1) << m_b;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if ({scl_o, rise_stb, fall_stb} !== {m_scl, m_rise, m_fall}) begin
        fails++;
        $display("FAIL R2/R3/R4 cycle %0d: scl/rise/fall=%b%b%b expected %b%b%b",
                 cyc, scl_o, rise_stb, fall_stb, m_scl, m_rise, m_fall);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    @(negedge clk);
    while (!rise_stb) @(negedge clk);
  endtask

  task automatic wait_fall();
    @(negedge clk);
    while (!fall_stb) @(negedge clk);
  endtask

  task automatic measure(string req, int b, int h, int l);
    int t0, t1, t2;
    wait_rise(); t0 = cyc;
    wait_fall(); t1 = cyc;
    wait_rise(); t2 = cyc;
    check({req, " high"}, t1 - t0, (h + 1) << b);
    check({req, " period"}, t2 - t0, (h + l + 2) << b);
  endtask

  task automatic restart(logic [19:0] w);
    @(negedge clk); en = 1'b0; timing_word = w;
    repeat (2) @(negedge clk);
    en = 1'b1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset scl", int'(scl_o), 1);
    check("R5 reset strobes", int'(rise_stb | fall_stb), 0);

    restart(word(0, 0, 0, 0));
    measure("R7 all-zero", 0, 0, 0);

    restart(word(1, 2, 4, 0));
    measure("R2 R3 b1h2l4", 1, 2, 4);

    restart(word(2, 7, 3, 8'hA5));
    measure("R1 junk bits b2h7l3", 2, 7, 3);

    restart(word(0, 15, 15, 0));
    measure("R8 max counts b0", 0, 15, 15);

    restart(word(3, 15, 15, 8'hff));
    measure("R8 max counts b3", 3, 15, 15);

    // R6: change the word during a high phase; the current period keeps the old one
    restart(word(1, 3, 3, 0));
    wait_rise();
    repeat (3) @(negedge clk);
    timing_word = word(0, 1, 5, 0);
    begin
      int t0, t1, t2;
      t0 = cyc - 3;
      wait_fall(); t1 = cyc;
      wait_rise(); t2 = cyc;
      check("R6 old high kept", t1 - t0, 8);
      check("R6 old period kept", t2 - t0, 16);
    end
    measure("R6 new word applied", 0, 1, 5);

    // R5: disable in the middle of a low phase, then re-enable
    restart(word(2, 1, 6, 0));
    wait_fall();
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R5 disabled scl", int'(scl_o), 1);
    timing_word = word(1, 2, 2, 0);
    @(negedge clk);
    check("R5 disabled strobes", int'(rise_stb | fall_stb), 0);
    en = 1'b1;
    begin
      int t0;
      t0 = cyc;
      wait_fall();
      check("R5 full first high", cyc - t0, 6);
    end

    // R8: largest exponent, one low phase measured
    restart(word(15, 0, 0, 0));
    begin
      int t0;
      wait_fall(); t0 = cyc;
      wait_rise();
      check("R8 b15 low", cyc - t0, 32768);
    end

    finish_run();
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule